// File: doc/BRIEF.md
# Burst Bus Target

This block is the responding side of a synchronous bus whose address and data share one set of 32 wires. An initiator opens a transaction by pulling a framing strobe low for one address cycle, presenting the address together with a three-bit command. The command names the address space (memory, I/O or configuration) and the direction. The target compares the space and the address against its own windows. When both match, it claims the transaction and moves 32-bit words between the bus and a small internal register array.

Every transfer is a burst. A single-word access is a burst of one data phase. A word moves only on a rising edge at which the initiator's ready strobe and the target's ready strobe are both low. The target can hold off its first ready for a programmable number of wait cycles. It steps its word pointer after each completed phase. It recognises the last phase because the framing strobe is already high during that phase. One cycle after the last phase completes, the target releases the bus.

Top module: `burst_target`

## Requirements
- R1: After synchronous reset, `tgt_rdy_n` is 1, `ad_oe` is 0, `ad_out` is 0 and every word of the array reads as zero.
- R2: During the address phase, `cmd[2:1]` selects the space: 00 memory, 01 I/O, 10 configuration, 11 none. `cmd[0]`=1 means write and 0 means read. The target claims the transaction when `ad_in[31:5]` equals bits 31:5 of that space's base. All three windows map onto the same eight-word array, indexed by `ad_in[4:2]`.
- R3: A transaction whose space or address does not match is ignored. `tgt_rdy_n` stays 1, `ad_oe` stays 0, and the array is unchanged.
- R4: `wait_cfg` (0 to 3) is sampled in the address phase. For a claimed transaction, `tgt_rdy_n` first goes low in the (W+1)-th cycle after the address cycle. After that it stays low until the final phase completes.
- R5: A data phase completes only on a rising edge where `init_rdy_n` and `tgt_rdy_n` are both 0. On a write, `ad_in` is stored at that edge.
- R6: Each completed phase advances the word pointer by one. The pointer wraps modulo the array depth. A single-word access behaves as a burst of length one.
- R7: While `init_rdy_n` is 1 in mid-burst, the pointer holds and the read data on `ad_out` stays stable.
- R8: A phase that completes with `txn_n` at 1 is the last one. In the next cycle `tgt_rdy_n` is 1, `ad_oe` is 0 and `ad_out` is 0.
- R9: From the cycle after a claimed read's address phase through its final phase, `ad_oe` is 1 and `ad_out` carries the word at the current pointer. During writes `ad_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all sampling and driving |
| rst | input | 1 | Synchronous active-high reset |
| txn_n | input | 1 | Transaction framing strobe, active low |
| init_rdy_n | input | 1 | Initiator-ready strobe, active low |
| cmd | input | 3 | Space and direction, valid in the address phase |
| ad_in | input | 32 | Address in the address phase, write data in data phases |
| wait_cfg | input | 2 | Wait cycles before the first target-ready |
| tgt_rdy_n | output | 1 | Target-ready strobe, active low |
| ad_oe | output | 1 | Target is driving read data |
| ad_out | output | 32 | Read data; zero when not driving |

## Verification
The assertions assume a well-formed initiator. It keeps `txn_n` low from the address cycle up to the final phase. It raises `txn_n` only in a cycle where `init_rdy_n` is low. It never shows both strobes high in mid-transaction. The stimulus tasks generate only such framing: stalls are inserted with `txn_n` still low, and at least one idle cycle separates transactions. Unclaimed transactions are ended by the bench pretending another target answered.

// File: rtl/bt_pkg.sv
package bt_pkg;

    localparam int DATA_W   = 32;
    localparam int N_SPACES = 3;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        SP_MEM  = 2'b00,
        SP_IO   = 2'b01,
        SP_CFG  = 2'b10,
        SP_NONE = 2'b11
    } space_e;

    typedef struct packed {
        space_e space;
        logic   wr;
    } cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_XFER = 2'b01,
        ST_SKIP = 2'b10
    } phase_e;

    // True when addr and base agree on every bit from lsb upward.
    function automatic logic in_window(word_t addr, word_t base, int unsigned lsb);
        word_t diff;
        diff = (addr ^ base) >> lsb;
        return diff == '0;
    endfunction

endpackage

// File: rtl/bt_decode.sv
module bt_decode
    import bt_pkg::*;
#(
    parameter int    AW       = 3,
    parameter word_t MEM_BASE = 32'h4000_0000,
    parameter word_t IO_BASE  = 32'h0000_1000,
    parameter word_t CFG_BASE = 32'h0000_0100
) (
    input  word_t          addr,
    input  cmd_t           cmd,
    output logic           hit,
    output logic [AW-1:0]  idx
);

    localparam int unsigned WIN_LSB = AW + 2;

    logic [N_SPACES-1:0] sp_hit;

    for (genvar g = 0; g < N_SPACES; g++) begin : g_space
        localparam word_t BASE = (g == 0) ? MEM_BASE :
                                 (g == 1) ? IO_BASE  : CFG_BASE;
        assign sp_hit[g] = (cmd.space == space_e'(g)) &&
                           in_window(addr, BASE, WIN_LSB);
    end

    assign hit = |sp_hit;
    assign idx = addr[AW+1:2];

endmodule

// File: rtl/bt_ctrl.sv
module bt_ctrl
    import bt_pkg::*;
#(
    parameter int AW     = 3,
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              txn_n,
    input  logic              init_rdy_n,
    input  logic              hit,
    input  logic              cmd_wr,
    input  logic [AW-1:0]     idx,
    input  logic [WAIT_W-1:0] wait_in,
    output logic              tgt_rdy_n,
    output logic              drive_rd,
    output logic              wr_en,
    output logic [AW-1:0]     ptr
);

    phase_e            st;
    logic [WAIT_W-1:0] wcnt;
    logic [AW-1:0]     ptr_q;
    logic              wr_q;

    logic addr_phase;
    logic ready;
    logic beat;

    assign addr_phase = (st == ST_IDLE) && !txn_n;
    assign ready      = (st == ST_XFER) && (wcnt == '0);
    assign beat       = ready && !init_rdy_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            wcnt  <= '0;
            ptr_q <= '0;
            wr_q  <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (!txn_n) begin
                        if (hit) begin
                            st    <= ST_XFER;
                            ptr_q <= idx;
                            wr_q  <= cmd_wr;
                            wcnt  <= wait_in;
                        end else begin
                            st <= ST_SKIP;
                        end
                    end
                end
                ST_XFER: begin
                    if (wcnt != '0) begin
                        wcnt <= wcnt - WAIT_W'(1);
                    end else if (!init_rdy_n) begin
                        ptr_q <= ptr_q + AW'(1);
                        if (txn_n) st <= ST_IDLE;
                    end
                end
                ST_SKIP: begin
                    if (txn_n && init_rdy_n) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign tgt_rdy_n = !ready;
    assign drive_rd  = (st == ST_XFER) && !wr_q;
    assign wr_en     = beat && wr_q;
    assign ptr       = ptr_q;

    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (addr_phase && hit && wait_in != '0) |=> tgt_rdy_n);                 // R4

    AST_RDY_KEEP: assert property (@(posedge clk) disable iff (rst)
        (!tgt_rdy_n && !(!init_rdy_n && txn_n)) |=> !tgt_rdy_n);             // R4

    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (addr_phase && !hit) |=> (tgt_rdy_n && !drive_rd));                  // R3

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!tgt_rdy_n && !init_rdy_n && !txn_n) |=> (ptr == $past(ptr) + AW'(1))); // R6

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tgt_rdy_n && init_rdy_n) |=> $stable(ptr));                         // R7

endmodule

// File: rtl/bt_regs.sv
module bt_regs
    import bt_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] ptr,
    input  word_t         wdata,
    output word_t         rdata
);

    word_t cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                cells[i] <= '0;
            end else if (wr_en && ptr == AW'(i)) begin
                cells[i] <= wdata;
            end
        end
    end

    assign rdata = cells[ptr];

endmodule

// File: rtl/burst_target.sv
module burst_target
    import bt_pkg::*;
#(
    parameter int    DEPTH    = 8,
    parameter int    WAIT_W   = 2,
    parameter word_t MEM_BASE = 32'h4000_0000,
    parameter word_t IO_BASE  = 32'h0000_1000,
    parameter word_t CFG_BASE = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              txn_n,
    input  logic              init_rdy_n,
    input  logic [2:0]        cmd,
    input  logic [31:0]       ad_in,
    input  logic [WAIT_W-1:0] wait_cfg,
    output logic              tgt_rdy_n,
    output logic              ad_oe,
    output logic [31:0]       ad_out
);

    localparam int AW = $clog2(DEPTH);

    cmd_t          cmd_s;
    logic          hit;
    logic [AW-1:0] idx;
    logic [AW-1:0] ptr;
    logic          drive_rd;
    logic          wr_en;
    word_t         rdata;

    assign cmd_s = cmd_t'(cmd);

    bt_decode #(
        .AW(AW), .MEM_BASE(MEM_BASE), .IO_BASE(IO_BASE), .CFG_BASE(CFG_BASE)
    ) u_decode (
        .addr(ad_in), .cmd(cmd_s), .hit(hit), .idx(idx)
    );

    bt_ctrl #(.AW(AW), .WAIT_W(WAIT_W)) u_ctrl (
        .clk(clk), .rst(rst), .txn_n(txn_n), .init_rdy_n(init_rdy_n),
        .hit(hit), .cmd_wr(cmd_s.wr), .idx(idx), .wait_in(wait_cfg),
        .tgt_rdy_n(tgt_rdy_n), .drive_rd(drive_rd), .wr_en(wr_en), .ptr(ptr)
    );

    bt_regs #(.DEPTH(DEPTH), .AW(AW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .ptr(ptr),
        .wdata(ad_in), .rdata(rdata)
    );

    assign ad_oe  = drive_rd;
    assign ad_out = drive_rd ? rdata : '0;

    AST_END_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (!tgt_rdy_n && !init_rdy_n && txn_n) |=> (tgt_rdy_n && !ad_oe));     // R8

    AST_READ_STABLE: assert property (@(posedge clk) disable iff (rst)
        (ad_oe && init_rdy_n && !tgt_rdy_n) |=> $stable(ad_out));             // R7

    AST_QUIET_OUT: assert property (@(posedge clk) disable iff (rst)
        (!ad_oe) |-> (ad_out == '0));                                         // R9

endmodule

// File: tb/burst_target_bench.sv
module burst_target_bench;

    localparam logic [31:0] MEM_B = 32'h4000_0000;
    localparam logic [31:0] IO_B  = 32'h0000_1000;
    localparam logic [31:0] CFG_B = 32'h0000_0100;
    localparam int          DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        txn_n;
    logic        init_rdy_n;
    logic [2:0]  cmd;
    logic [31:0] ad_in;
    logic [1:0]  wait_cfg;
    logic        tgt_rdy_n;
    logic        ad_oe;
    logic [31:0] ad_out;

    int checks = 0;
    int fails  = 0;
    logic [31:0] ref_mem [DEPTH];

    always #10 clk = ~clk;

    burst_target #(
        .DEPTH(DEPTH), .WAIT_W(2), .MEM_BASE(MEM_B), .IO_BASE(IO_B), .CFG_BASE(CFG_B)
    ) u_burst_target (
        .clk(clk), .rst(rst), .txn_n(txn_n), .init_rdy_n(init_rdy_n),
        .cmd(cmd), .ad_in(ad_in), .wait_cfg(wait_cfg),
        .tgt_rdy_n(tgt_rdy_n), .ad_oe(ad_oe), .ad_out(ad_out)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit bench_hit(input logic [1:0] sp, input logic [31:0] a);
        logic [31:0] base;
        case (sp)
            2'b00:   base = MEM_B;
            2'b01:   base = IO_B;
            2'b10:   base = CFG_B;
            default: return 1'b0;
        endcase
        return a[31:5] == base[31:5];
    endfunction

    // One transaction, checked against a behavioural model every cycle.
    task automatic burst(input logic [1:0] sp, input bit wr, input logic [31:0] addr,
                         input int n, input int w, input int stall_at, input int stall_len,
                         input logic [31:0] seed, input string req);
        bit          hit;
        int          idx;
        int          k;
        int          wrem;
        int          stall_left;
        bit          stall_done;
        bit          stalling;
        bit          exp_rdy;
        logic [31:0] wdata;
        hit        = bench_hit(sp, addr);
        idx        = int'(addr[4:2]);
        k          = 0;
        wrem       = w;
        stall_left = 0;
        stall_done = 1'b0;
        @(negedge clk);
        chk(req, "idle tgt_rdy_n", tgt_rdy_n, 1);
        chk(req, "idle ad_oe", ad_oe, 0);
        txn_n      = 1'b0;
        init_rdy_n = 1'b1;
        ad_in      = addr;
        cmd        = {sp, wr};
        wait_cfg   = 2'(w);
        @(posedge clk);
        while (k < n) begin
            @(negedge clk);
            exp_rdy = hit && (wrem == 0);
            chk(req, "tgt_rdy_n", tgt_rdy_n, !exp_rdy);
            chk(req, "ad_oe", ad_oe, hit && !wr);
            if (hit && !wr) chk(req, "read word", ad_out, ref_mem[idx]);
            else            chk(req, "ad_out quiet", ad_out, 0);
            if (!stall_done && stall_at >= 0 && k == stall_at) begin
                stall_left = stall_len;
                stall_done = 1'b1;
            end
            stalling = stall_left > 0;
            if (stalling) stall_left--;
            wdata      = seed + 32'(k) * 32'h0011_0011;
            init_rdy_n = stalling;
            txn_n      = !stalling && (k == n - 1);
            ad_in      = stalling ? 32'hDEAD_BEEF : wdata;
            cmd        = 3'b111;
            wait_cfg   = 2'd3;
            @(posedge clk);
            if (hit && wrem > 0) begin
                wrem--;
            end else if (!stalling) begin
                if (hit && wr) ref_mem[idx] = wdata;
                if (hit) idx = (idx + 1) % DEPTH;
                k++;
            end
        end
        @(negedge clk);
        txn_n      = 1'b1;
        init_rdy_n = 1'b1;
        ad_in      = 32'h0;
        chk("R8", "release tgt_rdy_n", tgt_rdy_n, 1);
        chk("R8", "release ad_oe", ad_oe, 0);
        chk("R8", "release ad_out", ad_out, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R5 watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 32'h0;
        rst = 1'b1; txn_n = 1'b1; init_rdy_n = 1'b1;
        cmd = 3'b000; ad_in = 32'h0; wait_cfg = 2'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset outputs and cleared array
        chk("R1", "reset tgt_rdy_n", tgt_rdy_n, 1);
        chk("R1", "reset ad_oe", ad_oe, 0);
        chk("R1", "reset ad_out", ad_out, 0);
        burst(2'b00, 1'b0, MEM_B, 8, 0, -1, 0, 32'h0, "R1");
        // R5/R6: four-word write burst without waits
        burst(2'b00, 1'b1, MEM_B, 4, 0, -1, 0, 32'hA000_0001, "R5");
        // R4/R9: four-word read after two wait cycles
        burst(2'b00, 1'b0, MEM_B, 4, 2, -1, 0, 32'h0, "R4");
        burst(2'b00, 1'b0, MEM_B + 32'h4, 3, 3, -1, 0, 32'h0, "R9");
        // R7: initiator stalls in a read and in a write
        burst(2'b00, 1'b0, MEM_B, 4, 1, 1, 2, 32'h0, "R7");
        burst(2'b00, 1'b1, MEM_B + 32'h8, 4, 0, 2, 3, 32'hB000_0010, "R7");
        burst(2'b00, 1'b0, MEM_B + 32'h8, 4, 0, 0, 1, 32'h0, "R7");
        // R2/R6: single-word accesses in the I/O and configuration windows
        burst(2'b01, 1'b1, IO_B + 32'h8, 1, 3, -1, 0, 32'hC0DE_0001, "R2");
        burst(2'b10, 1'b1, CFG_B + 32'h1C, 1, 1, -1, 0, 32'hC0DE_0002, "R2");
        burst(2'b01, 1'b0, IO_B + 32'h1C, 1, 0, -1, 0, 32'h0, "R2");
        burst(2'b10, 1'b0, CFG_B + 32'h8, 1, 2, -1, 0, 32'h0, "R6");
        // R3: wrong space, reserved space, outside the window
        burst(2'b01, 1'b1, MEM_B, 2, 0, -1, 0, 32'hEE00_0001, "R3");
        burst(2'b11, 1'b1, MEM_B, 2, 0, 0, 1, 32'hEE00_0002, "R3");
        burst(2'b00, 1'b1, MEM_B + 32'h20, 2, 0, -1, 0, 32'hEE00_0003, "R3");
        burst(2'b00, 1'b0, CFG_B, 1, 0, -1, 0, 32'h0, "R3");
        burst(2'b00, 1'b0, MEM_B, 8, 0, -1, 0, 32'h0, "R3");
        // R6: pointer wraps from the last word to the first
        burst(2'b00, 1'b1, MEM_B + 32'h18, 3, 0, -1, 0, 32'h1234_0000, "R6");
        burst(2'b00, 1'b0, MEM_B + 32'h18, 3, 1, -1, 0, 32'h0, "R6");
        // R5: back-to-back single reads
        burst(2'b00, 1'b0, MEM_B + 32'h10, 1, 0, -1, 0, 32'h0, "R5");
        burst(2'b00, 1'b0, MEM_B + 32'h14, 1, 0, -1, 0, 32'h0, "R5");
        repeat (2) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule